// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

A single timer channel driven through a word-wide register port. A counter decrements once per tick. The tick comes from a free-running prescaler, so the channel can count every clock cycle, every 16th cycle or every 256th cycle. The channel runs in one of three ways:

- **Free-running:** the count wraps to all ones.
- **Periodic:** the count reloads from a stored reload value.
- **One-shot:** the count stops at zero.

Each of these can use a 16-bit or a 32-bit count.

When the count steps from one to zero, a raw interrupt flag is set. The flag is ANDed with an enable bit to drive the single interrupt output, and software clears it by writing the clear register. The reload value can be written two ways. One write also restarts the count at once. A second, background write takes effect only at the next periodic reload. In 16-bit mode the upper half of the count register is kept, and reads return it.

Top module: `dtc_channel`

## Requirements
- R1: After reset, CONTROL reads 0x20, VALUE reads 0xFFFFFFFF, LOAD reads 0, RIS reads 0 and `irq` is low. The channel is then disabled, in 16-bit, free-running mode.
- R2: Word offsets are LOAD 0x00, VALUE 0x04, CONTROL 0x08, INTCLR 0x0C, RIS 0x10, MIS 0x14 and BGLOAD 0x18. Address bits 1:0 are ignored and any other offset reads 0.
  - CONTROL bit 7 = enable.
  - CONTROL bit 6 = periodic (0 = free-running).
  - CONTROL bit 5 = interrupt enable.
  - CONTROL bits 3:2 = prescale.
  - CONTROL bit 1 = 32-bit width (0 = 16-bit).
  - CONTROL bit 0 = one-shot.
  - Every other CONTROL bit reads 0.
- R3: The count changes only on a tick, and ticks occur only while enable is 1. A disabled channel holds VALUE.
- R4: The prescaler counts clock cycles from reset. Prescale 00 ticks every cycle. Prescale 01 ticks when the low 4 prescaler bits are all ones. Prescale 10 and prescale 11 both tick when the low 8 prescaler bits are all ones.
- R5: A LOAD write stores all 32 bits as the reload value. In the same cycle it loads the count, replacing any tick: all 32 bits in 32-bit mode, only the low 16 bits in 16-bit mode.
- R6: A BGLOAD write stores the reload value and leaves the count untouched. Offsets 0x00 and 0x18 read the same reload value.
- R7: In free-running mode, a tick at count zero wraps the active width to all ones and raises no interrupt.
- R8: In periodic mode, a tick at count zero loads the active width from the reload value, and the reload value used is the one held before that cycle's write.
- R9: RIS is set by the tick that moves the count from 1 to 0. Any INTCLR write clears it, but a set in the same cycle wins.
- R10: `irq` and MIS both equal RIS AND the CONTROL interrupt enable bit.
- R11: In one-shot mode the count stays at zero after the 1-to-0 tick. Two things re-arm it: a CONTROL write with enable = 1, after which the next tick at zero reloads by mode, or a LOAD write whose active bits are nonzero.
- R12: In 16-bit mode, VALUE bits 31:16 never change. Switching width changes no stored bit of VALUE or LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe for the offset in `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The bench goes after these corner cases:

- **Clear and set in the same cycle.** A design that gave INTCLR priority over the 1-to-0 tick would lose an interrupt. The bench clears the flag in exactly that cycle.
- **Prescale setting 11.** A wrong decode would tick at a third rate.
- **Upper half in 16-bit mode.** Careless merging would zero or corrupt bits 31:16. The bench flips the width back and forth with distinct upper halves in VALUE and LOAD.
- **Expired one-shot.** Without a re-arm path the count would stick at zero. Without the hold it would keep reloading.
- **Background write.** A background write that moved the count would show in the very next VALUE read.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int CNT_W  = 32;
  localparam int HALF_W = CNT_W / 2;

  // word index of each register (address bits 4:2)
  localparam logic [2:0] IDX_RELOAD = 3'd0;
  localparam logic [2:0] IDX_COUNT  = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_CLEAR  = 3'd3;
  localparam logic [2:0] IDX_RAW    = 3'd4;
  localparam logic [2:0] IDX_MASKED = 3'd5;
  localparam logic [2:0] IDX_BGRLD  = 3'd6;

  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       inten;     // bit 5
    logic [1:0] psel;      // bits 3:2
    logic       w32;       // bit 1
    logic       oneshot;   // bit 0
  } dtc_ctrl_t;

  localparam dtc_ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, inten: 1'b1,
                                       psel: 2'b00, w32: 1'b0, oneshot: 1'b0};

  function automatic dtc_ctrl_t f_unpack_ctrl(input logic [7:0] b);
    dtc_ctrl_t c;
    c.run      = b[7];
    c.periodic = b[6];
    c.inten    = b[5];
    c.psel     = b[3:2];
    c.w32      = b[1];
    c.oneshot  = b[0];
    return c;
  endfunction

  function automatic logic [7:0] f_pack_ctrl(input dtc_ctrl_t c);
    return {c.run, c.periodic, c.inten, 1'b0, c.psel, c.w32, c.oneshot};
  endfunction

  // bits of the count that take part in counting
  function automatic logic [CNT_W-1:0] f_active_mask(input logic w32);
    return w32 ? {CNT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  endfunction

  // replace only the active bits of 'keep' with those of 'nv'
  function automatic logic [CNT_W-1:0] f_merge(input logic w32,
                                               input logic [CNT_W-1:0] keep,
                                               input logic [CNT_W-1:0] nv);
    logic [CNT_W-1:0] m;
    m = f_active_mask(w32);
    return (keep & ~m) | (nv & m);
  endfunction

endpackage

// File: rtl/dtc_prescale.sv
module dtc_prescale #(
  parameter int DIV_A_LOG = 4,
  parameter int DIV_B_LOG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam int PRE_W = (DIV_B_LOG > DIV_A_LOG) ? DIV_B_LOG : DIV_A_LOG;
  localparam logic [PRE_W-1:0] MASK_A = PRE_W'((1 << DIV_A_LOG) - 1);
  localparam logic [PRE_W-1:0] MASK_B = PRE_W'((1 << DIV_B_LOG) - 1);

  logic [PRE_W-1:0] pre_q;
  logic             wrap_a, wrap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign wrap_a = (pre_q & MASK_A) == MASK_A;
  assign wrap_b = (pre_q & MASK_B) == MASK_B;

  always_comb begin
    unique case (psel)
      2'b00:   tick = run;
      2'b01:   tick = run & wrap_a;
      default: tick = run & wrap_b;  // 10 and the undefined 11 alike
    endcase
  end
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter
  import dtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             w32,
  input  logic             periodic,
  input  logic             oneshot,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             rearm,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d, act, refill;
  logic             exp_q, exp_d, at_zero, at_one, parked;

  assign act     = cnt_q & f_active_mask(w32);
  assign at_zero = (act == '0);
  assign at_one  = (act == CNT_W'(1));
  assign parked  = oneshot & exp_q;
  assign hit     = tick & ~ld_wr & at_one;
  assign refill  = periodic ? reload_val : {CNT_W{1'b1}};

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (ld_wr) begin
      cnt_d = f_merge(w32, cnt_q, ld_data);
      if ((ld_data & f_active_mask(w32)) != '0) exp_d = 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (!parked) cnt_d = f_merge(w32, cnt_q, refill);
      end else begin
        cnt_d = f_merge(w32, cnt_q, act - 1'b1);
        if (at_one && oneshot) exp_d = 1'b1;
      end
    end
    if (rearm) exp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= {CNT_W{1'b1}};
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt     = cnt_q;
  assign expired = exp_q;
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter int DIV_A_LOG = 4,
  parameter int DIV_B_LOG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  dtc_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q, cnt;
  logic             ris_q, tick, hit, expired;
  logic             ld_wr, bg_wr, clr_wr, ctl_wr, rearm;
  logic [2:0]       idx;
  logic [1:0]       addr_lsb_unused;

  assign idx             = reg_addr[4:2];
  assign addr_lsb_unused = reg_addr[1:0];

  // named write events
  assign ld_wr  = reg_wr & (idx == IDX_RELOAD);
  assign bg_wr  = reg_wr & (idx == IDX_BGRLD);
  assign clr_wr = reg_wr & (idx == IDX_CLEAR);
  assign ctl_wr = reg_wr & (idx == IDX_CTRL);
  assign rearm  = ctl_wr & reg_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
      ris_q    <= 1'b0;
    end else begin
      if (ctl_wr)          ctrl_q   <= f_unpack_ctrl(reg_wdata[7:0]);
      if (ld_wr || bg_wr)  reload_q <= reg_wdata;
      if (hit)             ris_q    <= 1'b1;
      else if (clr_wr)     ris_q    <= 1'b0;
    end
  end

  dtc_prescale #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.run),
    .psel (ctrl_q.psel),
    .tick (tick)
  );

  dtc_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .w32       (ctrl_q.w32),
    .periodic  (ctrl_q.periodic),
    .oneshot   (ctrl_q.oneshot),
    .reload_val(reload_q),
    .ld_wr     (ld_wr),
    .ld_data   (reg_wdata),
    .rearm     (rearm),
    .cnt       (cnt),
    .hit       (hit),
    .expired   (expired)
  );

  assign irq = ris_q & ctrl_q.inten;

  always_comb begin
    unique case (idx)
      IDX_RELOAD, IDX_BGRLD: reg_rdata = reload_q;
      IDX_COUNT:             reg_rdata = cnt;
      IDX_CTRL:              reg_rdata = {24'd0, f_pack_ctrl(ctrl_q)};
      IDX_RAW:               reg_rdata = {31'd0, ris_q};
      IDX_MASKED:            reg_rdata = {31'd0, irq};
      default:               reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtc_channel_chk.sv
module dtc_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ld_wr,
  input logic        bg_wr,
  input logic        clr_wr,
  input logic        hit,
  input logic        ris,
  input logic        oneshot,
  input logic        w32,
  input logic        expired,
  input logic [31:0] cnt
);
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_wr) |=> $stable(cnt));

  a_r6_bgload_leaves_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_wr && !tick) |=> $stable(cnt));

  a_r9_hit_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ris);

  a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !hit) |=> !ris);

  a_r11_parked_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && expired && !ld_wr) |=> $stable(cnt));

  a_r12_upper_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !w32 |=> $stable(cnt[31:16]));
endmodule

bind dtc_channel dtc_channel_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .ld_wr  (ld_wr),
  .bg_wr  (bg_wr),
  .clr_wr (clr_wr),
  .hit    (hit),
  .ris    (ris_q),
  .oneshot(ctrl_q.oneshot),
  .w32    (ctrl_q.w32),
  .expired(expired),
  .cnt    (cnt)
);

// File: tb/test_dtc_channel.sv
module test_dtc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = 5'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int unsigned m_ctrl, m_load, m_cnt, m_pre;
  bit          m_ris, m_exp;

  always #10 clk = ~clk;  // 50 MHz

  dtc_channel i_dtc_channel (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit m_tick();
    int unsigned ps;
    if (((m_ctrl >> 7) & 1) == 0) return 0;
    ps = (m_ctrl >> 2) & 3;
    if (ps == 0) return 1;
    if (ps == 1) return (m_pre % 16) == 15;
    return (m_pre % 256) == 255;
  endfunction

  task automatic model(bit wr, logic [4:0] a, logic [31:0] d);
    int unsigned mask, act, nc;
    bit nr, ne, tk, one, per, is_ld;
    mask  = ((m_ctrl >> 1) & 1) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    act   = m_cnt & mask;
    tk    = m_tick();
    one   = (m_ctrl & 1) != 0;
    per   = ((m_ctrl >> 6) & 1) != 0;
    is_ld = wr && (a[4:2] == 0);
    nc = m_cnt; nr = m_ris; ne = m_exp;
    if (wr && a[4:2] == 3) nr = 0;
    if (is_ld) begin
      nc = (m_cnt & ~mask) | (d & mask);
      if ((d & mask) != 0) ne = 0;
    end else if (tk) begin
      if (act == 0) begin
        if (!(one && m_exp)) nc = (m_cnt & ~mask) | ((per ? m_load : 32'hFFFF_FFFF) & mask);
      end else begin
        nc = (m_cnt & ~mask) | ((act - 1) & mask);
        if (act == 1) begin
          nr = 1;
          if (one) ne = 1;
        end
      end
    end
    if (wr && a[4:2] == 2) begin
      m_ctrl = d & 32'hEF;
      if (d[7]) ne = 0;
    end
    if (wr && (a[4:2] == 0 || a[4:2] == 6)) m_load = d;
    m_cnt = nc; m_ris = nr; m_exp = ne;
    m_pre++;
  endtask

  function automatic bit m_irq();
    return m_ris && (((m_ctrl >> 5) & 1) != 0);
  endfunction

  task automatic step(bit wr, logic [4:0] a, logic [31:0] d);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model(wr, a, d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 5'h04;
    #1;
    chk(cur_req, "VALUE", reg_rdata, m_cnt);
    chk(cur_req, "irq", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'h04, 32'd0);
  endtask

  task automatic rd(string req, string what, logic [4:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, what, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_ctrl = 32'h20; m_load = 0; m_cnt = 32'hFFFF_FFFF; m_pre = 0; m_ris = 0; m_exp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1", "CONTROL", 5'h08, 32'h20);
    rd("R1", "VALUE", 5'h04, 32'hFFFF_FFFF);
    rd("R1", "LOAD", 5'h00, 32'h0);
    rd("R1", "RIS", 5'h10, 32'h0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);

    // R2 field layout, reserved bits, offset decode
    cur_req = "R2";
    step(1'b1, 5'h08, 32'hFFFF_FF10);
    rd("R2", "CONTROL reserved", 5'h08, 32'h0);
    step(1'b1, 5'h08, 32'hFFFF_FFFF);
    rd("R2", "CONTROL all", 5'h08, 32'hEF);
    rd("R2", "CONTROL lsb alias", 5'h0B, 32'hEF);
    rd("R2", "unmapped", 5'h1C, 32'h0);
    step(1'b1, 5'h08, 32'h20);

    // R3 disabled channel holds, then counts when enabled
    cur_req = "R3";
    idle(5);
    rd("R3", "held VALUE", 5'h04, 32'hFFFF_FFFF);
    step(1'b1, 5'h08, 32'hA0);
    idle(10);

    // R5/R7/R9/R10 LOAD write, free-running wrap, flag
    cur_req = "R5";
    step(1'b1, 5'h00, 32'h1234_0005);
    rd("R5", "LOAD readback", 5'h00, 32'h1234_0005);
    cur_req = "R7";
    idle(8);
    rd("R9", "RIS after hit", 5'h10, {31'd0, m_ris});
    cur_req = "R9";
    step(1'b1, 5'h0C, 32'h0);
    rd("R9", "RIS cleared", 5'h10, 32'h0);
    step(1'b1, 5'h00, 32'h2);
    step(1'b0, 5'h04, 32'h0);
    step(1'b1, 5'h0C, 32'h0);   // clear in the hit cycle: set wins
    rd("R9", "set beats clear", 5'h10, 32'h1);
    cur_req = "R10";
    step(1'b1, 5'h08, 32'h80);
    rd("R10", "MIS masked", 5'h14, 32'h0);
    rd("R10", "RIS raw", 5'h10, 32'h1);
    step(1'b1, 5'h08, 32'hA0);
    rd("R10", "MIS unmasked", 5'h14, 32'h1);
    step(1'b1, 5'h0C, 32'h0);

    // R8 periodic 32-bit, R6 background reload
    cur_req = "R8";
    step(1'b1, 5'h08, 32'hE2);
    step(1'b1, 5'h00, 32'h3);
    idle(12);
    cur_req = "R6";
    step(1'b1, 5'h18, 32'h7);
    rd("R6", "LOAD after BGLOAD", 5'h00, 32'h7);
    rd("R6", "BGLOAD readback", 5'h18, 32'h7);
    idle(20);

    // R11 one-shot hold and re-arm
    cur_req = "R11";
    step(1'b1, 5'h08, 32'hE3);
    step(1'b1, 5'h00, 32'h2);
    idle(10);
    rd("R11", "parked at zero", 5'h04, 32'h0);
    step(1'b1, 5'h08, 32'hE3);
    idle(10);
    step(1'b1, 5'h00, 32'h4);
    idle(10);

    // R12 width switching keeps upper half
    cur_req = "R12";
    step(1'b1, 5'h08, 32'hE2);
    step(1'b1, 5'h00, 32'hABCD_0010);
    idle(3);
    step(1'b1, 5'h08, 32'hE0);
    idle(40);
    rd("R12", "upper half", 5'h04, {16'hABCD, m_cnt[15:0]});
    step(1'b1, 5'h08, 32'hA0);
    idle(30);
    step(1'b1, 5'h08, 32'hE2);
    idle(3);

    // R4 prescale settings
    cur_req = "R4";
    step(1'b1, 5'h08, 32'hA4);
    step(1'b1, 5'h00, 32'h20);
    idle(80);
    step(1'b1, 5'h08, 32'hA8);
    idle(600);
    step(1'b1, 5'h08, 32'hAC);
    idle(600);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule